// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides what advances a general-purpose timer and then runs the timer itself: a prescaler, an up-counter that wraps at a reload value, and a repetition down-counter. In the internal modes the prescaler steps on every bus clock while counting is enabled. In the event mode the prescaler steps only on rising edges of a selected trigger input, so the timer acts as an event counter. The trigger input is synchronised and edge-detected in the bus-clock domain, and the resulting pulse is used as a clock enable, not as a clock.

A software update request reloads the timer. It clears the counter and the prescaler, takes on new prescaler and reload values, and reloads the repetition counter. When the software trigger is the selected trigger source, the event mode never counts, and the software request only produces an update. The repetition-qualified update lets a consumer act only on every (N+1)-th update.

Top module: `tick_source_timer`

## Requirements
- R1: While reset is held, `cnt_out`, `upd_evt` and `rep_upd` are all 0.
- R2: With `mode_sel` at any value from 0 to 6 and `cnt_en` high, the prescaler steps on every clock. The counter advances once every (active prescale + 1) clocks.
- R3: With `mode_sel` = 7 and a nonzero `trig_sel`, the prescaler steps once per rising edge of the selected trigger input. Each edge passes through a two-flop synchroniser. A trigger held high gives only one step.
- R4: A `trig_sel` value of k (1 to N_TRIG) selects `trig_in[k-1]`. The other trigger inputs have no effect on the count.
- R5: With `mode_sel` = 7 and `trig_sel` = 0, the trigger inputs never advance the count. A `sw_update` pulse then clears the counter and raises `upd_evt`.
- R6: When the counter advances while equal to the active reload value, it wraps to 0. `upd_evt` is high in the same cycle in which `cnt_out` first shows that 0.
- R7: `rep_upd` accompanies an overflow update only when the repetition counter is 0. The repetition counter then reloads from `rep_val`; otherwise it decrements. With `rep_val` = R, `rep_upd` marks every (R+1)-th overflow.
- R8: In any mode, a cycle with `sw_update` high clears the counter and the prescaler and reloads the repetition counter from `rep_val`. One cycle later `cnt_out` is 0 and `upd_evt` and `rep_upd` are both high.
- R9: While `cnt_en` is low and no software update occurs, `cnt_out` holds its value.
- R10: New `psc_val` and `reload_val` values take effect only at the next update event, whether that event is an overflow or a software update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 3 | Slave-mode code; 7 selects event counting, all others the bus clock |
| trig_sel | input | SEL_W | 0 selects the software request, k selects trig_in[k-1] |
| trig_in | input | N_TRIG | Asynchronous external trigger inputs |
| sw_update | input | 1 | Software update request, one update per high cycle |
| cnt_en | input | 1 | Counting enable |
| psc_val | input | PSC_W | Prescale value, divide by value + 1 |
| reload_val | input | CNT_W | Counter wrap value |
| rep_val | input | REP_W | Repetition reload value |
| cnt_out | output | CNT_W | Counter value |
| upd_evt | output | 1 | Update event pulse |
| rep_upd | output | 1 | Repetition-qualified update pulse |

## Verification
Some rules are checked on every cycle. A software request must yield a cleared counter with both update flags one cycle later. Every update must show a zero count, and a repetition update never appears without an update. The count must hold while disabled or while the event mode has the software trigger selected, and it must never jump by more than one. Other behaviour only shows in the bench scenarios, which compare against a reference model: the divide ratio, the synchroniser latency, the single count for a long trigger pulse, immunity to unselected triggers, the ratio of repetition updates to updates, and the deferred take-up of new prescale and reload values.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;
  typedef enum logic [2:0] {
    SM_OFF   = 3'd0,
    SM_ENC1  = 3'd1,
    SM_ENC2  = 3'd2,
    SM_ENC3  = 3'd3,
    SM_RST   = 3'd4,
    SM_GATE  = 3'd5,
    SM_START = 3'd6,
    SM_EVENT = 3'd7
  } slave_mode_e;
endpackage

// File: rtl/tss_trig_edge.sv
`timescale 1ns/1ps
module tss_trig_edge #(
  parameter int N_TRIG = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  trig_sel,
  output logic              edge_o
);
  logic [N_TRIG-1:0] meta_q, sync_q;
  logic              picked, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= trig_in;
      sync_q <= meta_q;
      prev_q <= picked;
    end
  end

  // selector value 0 is the software source: no level from the pins
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_TRIG; i++) begin
      if (trig_sel == SEL_W'(i + 1)) picked = sync_q[i];
    end
  end

  assign edge_o = picked & ~prev_q;
endmodule

// File: rtl/tss_prescaler.sv
`timescale 1ns/1ps
module tss_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [PSC_W-1:0] psc_val_i,
  output logic             carry_o
);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] cnt_q, cnt_d, act_q, act_d;
  logic             at_top;

  assign at_top  = (cnt_q == act_q);
  assign carry_o = tick_i & at_top & ~clear_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (tick_i) cnt_d = at_top ? '0 : cnt_q + PSC_ONE;
    act_d = load_i ? psc_val_i : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/tss_counter.sv
`timescale 1ns/1ps
module tss_counter #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [REP_W-1:0] rep_val_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             rep_upd_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, top_q, top_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             upd_d, rupd_d, upd_q, rupd_q;

  assign ovf_o = step_i & (cnt_q == top_q) & ~force_i;

  always_comb begin
    cnt_d  = cnt_q;
    top_d  = top_q;
    rep_d  = rep_q;
    upd_d  = 1'b0;
    rupd_d = 1'b0;
    if (force_i) begin
      cnt_d  = '0;
      top_d  = reload_val_i;
      rep_d  = rep_val_i;
      upd_d  = 1'b1;
      rupd_d = 1'b1;
    end else if (step_i) begin
      if (ovf_o) begin
        cnt_d = '0;
        top_d = reload_val_i;
        upd_d = 1'b1;
        if (rep_q == '0) begin
          rep_d  = rep_val_i;
          rupd_d = 1'b1;
        end else begin
          rep_d = rep_q - REP_ONE;
        end
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      top_q  <= '0;
      rep_q  <= '0;
      upd_q  <= 1'b0;
      rupd_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      top_q  <= top_d;
      rep_q  <= rep_d;
      upd_q  <= upd_d;
      rupd_q <= rupd_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign upd_o     = upd_q;
  assign rep_upd_o = rupd_q;
endmodule

// File: rtl/tick_source_timer.sv
`timescale 1ns/1ps
module tick_source_timer #(
  parameter int  CNT_W  = 16,
  parameter int  PSC_W  = 16,
  parameter int  REP_W  = 8,
  parameter int  N_TRIG = 3,
  localparam int SEL_W  = $clog2(N_TRIG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic              sw_update,
  input  logic              cnt_en,
  input  logic [PSC_W-1:0]  psc_val,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic [REP_W-1:0]  rep_val,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              upd_evt,
  output logic              rep_upd
);
  import tss_pkg::*;

  logic rst_meta_q, rst_s_n;
  logic trig_edge, event_mode, psc_tick, psc_carry, cnt_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  tss_trig_edge #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst_n(rst_s_n), .trig_in(trig_in),
    .trig_sel(trig_sel), .edge_o(trig_edge)
  );

  // codes other than event mode keep the bus clock as the tick source
  assign event_mode = (slave_mode_e'(mode_sel) == SM_EVENT);
  assign psc_tick   = cnt_en & (event_mode ? trig_edge : 1'b1);

  tss_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_s_n), .tick_i(psc_tick), .clear_i(sw_update),
    .load_i(sw_update | cnt_ovf), .psc_val_i(psc_val), .carry_o(psc_carry)
  );

  tss_counter #(.CNT_W(CNT_W), .REP_W(REP_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .step_i(psc_carry), .force_i(sw_update),
    .reload_val_i(reload_val), .rep_val_i(rep_val), .ovf_o(cnt_ovf),
    .cnt_o(cnt_out), .upd_o(upd_evt), .rep_upd_o(rep_upd)
  );
endmodule

// File: rtl/tss_checker.sv
`timescale 1ns/1ps
module tss_checker #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic [2:0]       mode_sel,
  input logic [SEL_W-1:0] trig_sel,
  input logic             cnt_en,
  input logic             sw_update,
  input logic [CNT_W-1:0] cnt_out,
  input logic             upd_evt,
  input logic             rep_upd
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r8_sw_forces_update: assert property (@(posedge clk) disable iff (!rst_s_n)
    sw_update |=> (upd_evt && rep_upd && cnt_out == '0));

  a_r6_update_shows_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    upd_evt |-> cnt_out == '0);

  a_r7_rep_implies_update: assert property (@(posedge clk) disable iff (!rst_s_n)
    rep_upd |-> upd_evt);

  a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cnt_en && !sw_update) |=> $stable(cnt_out));

  a_r5_no_count_sw_source: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_sel == 3'd7 && trig_sel == '0 && !sw_update) |=> $stable(cnt_out));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$past(sw_update) |-> (cnt_out == $past(cnt_out) ||
                           cnt_out == $past(cnt_out) + ONE || cnt_out == '0));
endmodule

bind tick_source_timer tss_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_tss_checker (
  .clk(clk), .rst_s_n(rst_s_n), .mode_sel(mode_sel), .trig_sel(trig_sel),
  .cnt_en(cnt_en), .sw_update(sw_update), .cnt_out(cnt_out),
  .upd_evt(upd_evt), .rep_upd(rep_upd)
);

// File: tb/test_tick_source_timer.sv
`timescale 1ns/1ps
module test_tick_source_timer;
  localparam int CNT_W = 16, PSC_W = 16, REP_W = 8, N_TRIG = 3, SEL_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] mode_sel;
  logic [SEL_W-1:0] trig_sel;
  logic [N_TRIG-1:0] trig_in;
  logic sw_update, cnt_en;
  logic [PSC_W-1:0] psc_val;
  logic [CNT_W-1:0] reload_val;
  logic [REP_W-1:0] rep_val;
  logic [CNT_W-1:0] cnt_out;
  logic upd_evt, rep_upd;

  int total = 0, fails = 0;
  bit done = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;

  tick_source_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W), .N_TRIG(N_TRIG)) i_tick_source_timer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_sel(trig_sel),
    .trig_in(trig_in), .sw_update(sw_update), .cnt_en(cnt_en),
    .psc_val(psc_val), .reload_val(reload_val), .rep_val(rep_val),
    .cnt_out(cnt_out), .upd_evt(upd_evt), .rep_upd(rep_upd));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int rs, m_psc, m_pact, m_cnt, m_ract, m_rep;
  bit m_upd, m_rupd, m_prev;
  bit m_s1[N_TRIG], m_s2[N_TRIG];

  always @(posedge clk) begin
    if (!rst_n || rs < 2) begin
      rs = (!rst_n) ? 0 : rs + 1;
      m_psc = 0; m_pact = 0; m_cnt = 0; m_ract = 0; m_rep = 0;
      m_upd = 0; m_rupd = 0; m_prev = 0;
      foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; end
    end else begin
      bit lvl, tick;
      int ts;
      ts = int'(trig_sel);
      lvl = (ts >= 1 && ts <= N_TRIG) ? m_s2[ts-1] : 1'b0;
      tick = cnt_en && (mode_sel != 3'd7 || (lvl && !m_prev));
      m_upd = 0; m_rupd = 0;
      if (sw_update) begin
        m_cnt = 0; m_psc = 0; m_pact = int'(psc_val); m_ract = int'(reload_val);
        m_rep = int'(rep_val); m_upd = 1; m_rupd = 1;
      end else if (tick) begin
        if (m_psc == m_pact) begin
          m_psc = 0;
          if (m_cnt == m_ract) begin
            m_cnt = 0; m_upd = 1;
            m_pact = int'(psc_val); m_ract = int'(reload_val);
            if (m_rep == 0) begin m_rupd = 1; m_rep = int'(rep_val); end
            else m_rep = m_rep - 1;
          end else m_cnt = m_cnt + 1;
        end else m_psc = m_psc + 1;
      end
      m_prev = lvl;
      foreach (m_s1[i]) begin m_s2[i] = m_s1[i]; m_s1[i] = trig_in[i]; end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (int'(cnt_out) != m_cnt || upd_evt != m_upd || rep_upd != m_rupd) begin
        fails++;
        $display("FAIL %s model: actual cnt=%0d upd=%0b rep=%0b expected cnt=%0d upd=%0b rep=%0b",
                 cur, cnt_out, upd_evt, rep_upd, m_cnt, m_upd, m_rupd);
      end
    end
  end

  task automatic sw_pulse();
    @(negedge clk) sw_update = 1;
    @(negedge clk) sw_update = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      done = 1; total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int nu, nr, mx;
    rst_n = 0; mode_sel = 0; trig_sel = 0; trig_in = 0; sw_update = 0;
    cnt_en = 0; psc_val = 0; reload_val = 0; rep_val = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(cnt_out), 0); chk("R1", int'(upd_evt), 0); chk("R1", int'(rep_upd), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur = "R2"; mode_sel = 3'd0; psc_val = 2; reload_val = 9; rep_val = 0;
    sw_pulse();
    cnt_en = 1;
    repeat (9) @(negedge clk);
    chk("R2", int'(cnt_out), 3);

    cur = "R9"; cnt_en = 0;
    repeat (5) @(negedge clk);
    chk("R9", int'(cnt_out), 3);

    cur = "R8"; mode_sel = 3'd5; cnt_en = 1;
    repeat (4) @(negedge clk);
    sw_pulse();
    chk("R8", int'(cnt_out), 0); chk("R8", int'(upd_evt), 1); chk("R8", int'(rep_upd), 1);

    cur = "R7"; mode_sel = 3'd2; cnt_en = 0; psc_val = 0; reload_val = 2; rep_val = 1;
    sw_pulse();
    cnt_en = 1; nu = 0; nr = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      nu += int'(upd_evt); nr += int'(rep_upd);
    end
    chk("R6", nu, 10); chk("R7", nr, 5);

    cur = "R10";
    while (cnt_out != 1) @(negedge clk);
    reload_val = 5; mx = 0;
    do begin
      @(negedge clk);
      if (int'(cnt_out) > mx) mx = int'(cnt_out);
    end while (!upd_evt);
    chk("R10", mx, 2);
    mx = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (int'(cnt_out) > mx) mx = int'(cnt_out);
    end
    chk("R10", mx, 5);

    cur = "R3"; cnt_en = 0; mode_sel = 3'd7; trig_sel = 2; psc_val = 0; reload_val = 100;
    sw_pulse();
    cnt_en = 1;
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        trig_in = {k[0], (k < 4), ~k[0]};
      end
    end
    @(negedge clk) trig_in = 0;
    repeat (4) @(negedge clk);
    chk("R3", int'(cnt_out), 3);

    cur = "R4";
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); trig_in = {k[0], 1'b0, ~k[0]};
    end
    @(negedge clk) trig_in = 0;
    repeat (4) @(negedge clk);
    chk("R4", int'(cnt_out), 3);

    cur = "R5"; trig_sel = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); trig_in = {3{k[0]}};
    end
    @(negedge clk) trig_in = 0;
    repeat (4) @(negedge clk);
    chk("R5", int'(cnt_out), 3);
    sw_pulse();
    chk("R5", int'(cnt_out), 0); chk("R5", int'(upd_evt), 1);
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule